// File: doc/BRIEF.md
# I2C Register Target with Auto-Incrementing Pointer

This block is a target on a two-wire open-drain serial bus. It gives a bus master byte access to a register file that lives outside the block. In a write transfer, the master sends the register index as the first byte after the device address. Any further bytes in that transfer are written to consecutive indices. To read, the master either issues a repeated start after setting the index or opens a new transfer. The target then returns bytes from the current index, and the index advances after every byte.

A block of related result registers can therefore be collected in one burst. An example is three pressure bytes followed by three temperature bytes, each most significant byte first. The register file is reached through a plain port. The index is always presented on the address output. Read data is expected combinationally from that index. Each written byte produces a one-cycle write strobe.

Both bus lines are brought into the system clock domain through a chain of flip-flops before any edge is decoded. The target pulls SDA low only through its output-enable. It never stretches the clock.

Top module: `i2c_ptr_target`

## Requirements
- R1: After reset, the output-enable is low, no write strobe is issued, and the register index is 0x00. A read issued before any index is written returns the byte at index 0x00.
- R2: When the 7-bit address in the first byte after a start equals parameter DEV_ADDR, the target drives SDA low during the ninth clock. Bit 0 of that byte selects the direction: 0 means write and 1 means read.
- R3: For any other address, the target does not acknowledge. It keeps SDA released for every later bit until the next start, and it issues no write strobe.
- R4: In a write transfer, the byte after the device address loads the index. Each later byte is acknowledged and produces exactly one single-cycle strobe, with the current index on the address output and the byte on the write-data output.
- R5: The index advances by one during the acknowledge clock of every data byte, for both reads and writes. A write burst therefore fills consecutive indices.
- R6: After a repeated start with the read bit set, the target shifts out the byte at the index, MSB first, and changes SDA only while SCL is low.
- R7: When the master acknowledges a read byte, the target sends the next byte at once. Six bytes read from a base index come back in index order.
- R8: The index is kept across both repeated starts and stops. A read at the start of a new transfer continues from where the previous transfer left the index.
- R9: The index wraps from 0xFF to 0x00.
- R10: After the master does not acknowledge a read byte, the target keeps SDA released for any further clocks. A later start is then served normally.
- R11: A start is SDA falling while SCL is high. It aborts any byte in progress and releases SDA. A stop is SDA rising while SCL is high, and it returns the target to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When 1, the target pulls SDA low |
| reg_addr | output | PTR_W | Current register index |
| reg_rdata | input | 8 | Register byte at reg_addr (combinational) |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to write at reg_addr |

## Verification
The stimulus covers several cases. There are single-byte reads and writes and a three-byte write burst. A six-byte read burst with distinct pressure and temperature values shows that bytes come out in order rather than merely being present. Reads without a preceding index write separate state kept over reset, over a stop and over a repeated start. A foreign device address and extra clocks after a master NACK show that SDA stays released in the HOLD-type states. Writing across index 0xFF shows the wrap.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_REG,
      ST_REG_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK,
      ST_HOLD
   } tgt_state_e;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '1;
      else        chain[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= '1;
         else        chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h5C,
   parameter int         PTR_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic              sda_s,
   input  logic [BYTE_W-1:0] reg_rdata,
   output logic              sda_oe,
   output logic [PTR_W-1:0]  ptr,
   output logic              ptr_load,
   output logic              reg_we,
   output logic [BYTE_W-1:0] reg_wdata
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   if (PTR_W < 1 || PTR_W > BYTE_W) begin : g_bad_ptr
      $error("i2c_tgt_engine: PTR_W must be 1..8");
   end

   tgt_state_e        st;
   logic [BYTE_W-1:0] sh;
   logic [CNT_W-1:0]  bitc;
   logic              rw_q;
   logic              rx_state;

   assign rx_state = (st == ST_DEV) || (st == ST_REG) || (st == ST_WR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         sh        <= '0;
         bitc      <= '0;
         rw_q      <= 1'b0;
         sda_oe    <= 1'b0;
         ptr       <= '0;
         ptr_load  <= 1'b0;
         reg_we    <= 1'b0;
         reg_wdata <= '0;
      end else begin
         reg_we   <= 1'b0;
         ptr_load <= 1'b0;
         if (start_evt) begin
            st     <= ST_DEV;
            bitc   <= '0;
            sda_oe <= 1'b0;
         end else if (stop_evt) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (rx_state && scl_rise && bitc != FULL) begin
            sh   <= {sh[BYTE_W-2:0], sda_s};
            bitc <= bitc + ONE;
         end else if (rx_state && scl_fall && bitc == FULL) begin
            bitc <= '0;
            case (st)
               ST_DEV: begin
                  if (sh[BYTE_W-1:1] == DEV_ADDR) begin
                     st     <= ST_DEV_ACK;
                     sda_oe <= 1'b1;
                     rw_q   <= sh[0];
                  end else begin
                     st <= ST_HOLD;
                  end
               end
               ST_REG: begin
                  ptr      <= sh[PTR_W-1:0];
                  ptr_load <= 1'b1;
                  st       <= ST_REG_ACK;
                  sda_oe   <= 1'b1;
               end
               default: begin
                  reg_we    <= 1'b1;
                  reg_wdata <= sh;
                  st        <= ST_WR_ACK;
                  sda_oe    <= 1'b1;
               end
            endcase
         end else begin
            case (st)
               ST_DEV_ACK: if (scl_fall) begin
                  if (rw_q) begin
                     st     <= ST_RD;
                     sh     <= reg_rdata;
                     sda_oe <= ~reg_rdata[BYTE_W-1];
                     bitc   <= ONE;
                  end else begin
                     st     <= ST_REG;
                     sda_oe <= 1'b0;
                     bitc   <= '0;
                  end
               end
               ST_REG_ACK: if (scl_fall) begin
                  st     <= ST_WR;
                  sda_oe <= 1'b0;
                  bitc   <= '0;
               end
               ST_WR_ACK: begin
                  if (scl_rise) ptr <= ptr + 1'b1;
                  if (scl_fall) begin
                     st     <= ST_WR;
                     sda_oe <= 1'b0;
                     bitc   <= '0;
                  end
               end
               ST_RD: if (scl_fall) begin
                  if (bitc == FULL) begin
                     st     <= ST_RD_ACK;
                     sda_oe <= 1'b0;
                  end else begin
                     sda_oe <= ~sh[BYTE_W-2];
                     sh     <= {sh[BYTE_W-2:0], 1'b0};
                     bitc   <= bitc + ONE;
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     ptr  <= ptr + 1'b1;
                     rw_q <= ~sda_s;
                  end
                  if (scl_fall) begin
                     if (rw_q) begin
                        st     <= ST_RD;
                        sh     <= reg_rdata;
                        sda_oe <= ~reg_rdata[BYTE_W-1];
                        bitc   <= ONE;
                     end else begin
                        st <= ST_HOLD;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target #(
   parameter logic [6:0] DEV_ADDR    = 7'h5C,
   parameter int         PTR_W       = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   output logic [PTR_W-1:0] reg_addr,
   input  logic [7:0]       reg_rdata,
   output logic             reg_we,
   output logic [7:0]       reg_wdata
);
   logic [1:0] bus_s;
   logic       scl_rise, scl_fall, start_evt, stop_evt, ptr_load;

   i2c_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) sync_i (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s)
   );

   i2c_cond_det det_i (
      .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt)
   );

   i2c_tgt_engine #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) eng_i (
      .clk(clk), .rst_n(rst_n),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt),
      .sda_s(bus_s[0]), .reg_rdata(reg_rdata),
      .sda_oe(sda_oe), .ptr(reg_addr), .ptr_load(ptr_load),
      .reg_we(reg_we), .reg_wdata(reg_wdata)
   );
endmodule

// File: rtl/i2c_ptr_target_chk.sv
module i2c_ptr_target_chk #(
   parameter int PTR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sda_oe,
   input logic             reg_we,
   input logic             scl_fall,
   input logic             start_evt,
   input logic             ptr_load,
   input logic [PTR_W-1:0] ptr
);
   // R4
   we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R4
   we_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> $past(scl_fall));

   // R6
   oe_rise_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> $past(scl_fall));

   // R11
   start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> !sda_oe);

   // R5 R9
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ptr_load && ptr != $past(ptr)) |-> ptr == PTR_W'($past(ptr) + 1'b1));
endmodule

bind i2c_ptr_target i2c_ptr_target_chk #(.PTR_W(PTR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .reg_we(reg_we),
   .scl_fall(scl_fall), .start_evt(start_evt), .ptr_load(ptr_load),
   .ptr(reg_addr)
);

// File: tb/i2c_ptr_target_tb_top.sv
module i2c_ptr_target_tb_top;
   localparam int Q = 10;
   localparam logic [6:0] DEV = 7'h5C;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe, reg_we;
   logic [7:0] reg_addr, reg_rdata, reg_wdata;
   logic sda_line;
   logic [7:0] mem [256];
   logic [7:0] model [256];
   logic [15:0] wr_q [$];
   logic [7:0] exp_ptr;
   int vectors = 0;
   int errs = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   assign sda_line  = sda_m & ~sda_oe;
   assign reg_rdata = mem[reg_addr];

   i2c_ptr_target #(.DEV_ADDR(DEV)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
      .reg_we(reg_we), .reg_wdata(reg_wdata)
   );

   function automatic logic [7:0] init_val(input int i);
      logic [7:0] v;
      v = 8'(i * 7) ^ 8'h3C;
      case (i)
         'h20: v = 8'h8A; 'h21: v = 8'h41; 'h22: v = 8'h07;
         'h23: v = 8'h19; 'h24: v = 8'hC2; 'h25: v = 8'h60;
         default: ;
      endcase
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
      end else if (reg_we) begin
         mem[reg_addr] <= reg_wdata;
      end
   end

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      vectors++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // scoreboard monitor for register writes (R4 R5 R9)
   always @(negedge clk) begin
      if (rst_n && reg_we) begin
         if (wr_q.size() == 0) begin
            vectors++; errs++;
            $display("FAIL R3/R4 unexpected write actual=%h:%h expected=none", reg_addr, reg_wdata);
         end else begin
            logic [15:0] e;
            e = wr_q.pop_front();
            chk(reg_addr, e[15:8], "R5 write index");
            chk(reg_wdata, e[7:0], "R4 write data");
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic recv_bit(output logic b);
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      b = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic write_byte(input logic [7:0] d, output logic acked);
      logic a;
      for (int k = 7; k >= 0; k--) send_bit(d[k]);
      recv_bit(a);
      acked = ~a;
   endtask

   task automatic read_byte(output logic [7:0] d, input logic mack);
      for (int k = 7; k >= 0; k--) recv_bit(d[k]);
      send_bit(~mack);
   endtask

   task automatic wr_burst(input logic [7:0] a, input int n,
                           input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
      logic ack;
      logic [7:0] d [3];
      d[0] = d0; d[1] = d1; d[2] = d2;
      bus_start();
      write_byte({DEV, 1'b0}, ack); chk(8'(ack), 8'd1, "R2 addr ack (write)");
      write_byte(a, ack);           chk(8'(ack), 8'd1, "R4 index ack");
      exp_ptr = a;
      for (int k = 0; k < n; k++) begin
         wr_q.push_back({exp_ptr, d[k]});
         model[exp_ptr] = d[k];
         exp_ptr = exp_ptr + 8'd1;
         write_byte(d[k], ack);     chk(8'(ack), 8'd1, "R4 data ack");
      end
      bus_stop();
   endtask

   task automatic rd_burst(input logic set_ptr, input logic [7:0] a, input int n,
                           input logic end_stop, input string tag);
      logic ack;
      logic [7:0] d;
      bus_start();
      if (set_ptr) begin
         write_byte({DEV, 1'b0}, ack); chk(8'(ack), 8'd1, "R2 addr ack (write)");
         write_byte(a, ack);           chk(8'(ack), 8'd1, "R4 index ack");
         exp_ptr = a;
         bus_start();
      end
      write_byte({DEV, 1'b1}, ack);    chk(8'(ack), 8'd1, "R2 addr ack (read)");
      for (int k = 0; k < n; k++) begin
         read_byte(d, k != n - 1);
         chk(d, model[exp_ptr], tag);
         exp_ptr = exp_ptr + 8'd1;
      end
      if (end_stop) bus_stop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errs++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
         $finish;
      end
   end

   initial begin
      logic ack;
      logic b;
      for (int i = 0; i < 256; i++) model[i] = init_val(i);
      tick(5);
      chk(8'(sda_oe), 8'd0, "R1 reset oe");
      chk(8'(reg_we), 8'd0, "R1 reset strobe");
      chk(reg_addr, 8'h00, "R1 reset index");
      rst_n = 1'b1;
      tick(5);
      // R1: read without writing the index
      exp_ptr = 8'h00;
      rd_burst(1'b0, 8'h00, 1, 1'b1, "R1 read at index 0");
      // R4 single write
      wr_burst(8'h10, 1, 8'h3C, 8'h00, 8'h00);
      // R5 burst write
      wr_burst(8'h40, 3, 8'hA1, 8'hB2, 8'hC3);
      // R6 single read with repeated start
      rd_burst(1'b1, 8'h10, 1, 1'b1, "R6 single read");
      // R7 six-byte result burst
      rd_burst(1'b1, 8'h20, 6, 1'b1, "R7 burst read");
      chk(reg_addr, 8'h26, "R5 index after burst");
      // R8 index survives stop
      rd_burst(1'b0, 8'h00, 1, 1'b1, "R8 read continues");
      // R3 foreign address
      bus_start();
      write_byte(8'h44, ack); chk(8'(ack), 8'd0, "R3 no ack addr");
      write_byte(8'h12, ack); chk(8'(ack), 8'd0, "R3 no ack data");
      bus_stop();
      chk(reg_addr, exp_ptr, "R3 index untouched");
      // R9 wrap
      wr_burst(8'hFF, 2, 8'h11, 8'h22, 8'h00);
      rd_burst(1'b1, 8'hFF, 2, 1'b1, "R9 wrap readback");
      // R10 NACK releases, then repeated start served
      rd_burst(1'b1, 8'h41, 1, 1'b0, "R10 read before nack");
      for (int k = 0; k < 9; k++) begin
         recv_bit(b);
         chk(8'(b), 8'd1, "R10 released after nack");
      end
      bus_start();
      write_byte({DEV, 1'b1}, ack); chk(8'(ack), 8'd1, "R11 start after hold");
      begin
         logic [7:0] d;
         read_byte(d, 1'b0);
         chk(d, model[exp_ptr], "R8 read after repeated start");
      end
      bus_stop();
      tick(20);
      vectors++;
      if (wr_q.size() != 0) begin
         errs++;
         $display("FAIL R4 missing writes actual=%0d expected=0", wr_q.size());
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end
endmodule